// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block sits between the bit shifter of a serial bus controller and the register file that software reads. Received bytes enter through a valid/ready write port and leave, oldest first, through a valid/ready read port. The read port's ready input is the pop strobe that a data-register read produces. The queue holds up to 16 bytes.

The shifter cannot be stalled, so back-pressure at the write port is advisory. `in_ready` is low exactly when the queue is full. A beat offered with `in_valid` high while `in_ready` is low is discarded, and it sets a sticky overflow flag. At the read port, `out_valid` is high whenever a byte is held and `out_data` shows the oldest byte. Asserting `out_ready` while `out_valid` is low does nothing.

Software programs a fill threshold and reads back an occupancy code. Both use a count-minus-one encoding. The level interrupt is sticky: it latches once the held count exceeds the threshold value and stays set until software clears it. If the condition still holds after a clear, it latches again. Draining the queue does not clear it. Software drains the queue by popping until `empty` rises, so `empty` is what qualifies an occupancy code of 0.

Top module: `rxq_watermark_fifo`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) empties the queue and clears `overflow` and `level_irq`. It also loads the threshold with 15 (`thr_q` = 15, `empty` = 1, `full` = 0).
- R2: Bytes leave through `out_data` in the order in which they were accepted.
- R3: `full` is 1 exactly when 16 bytes are held and `empty` is 1 exactly when none are held. `in_ready` equals not `full` and `out_valid` equals not `empty`.
- R4: A write beat offered while the queue is full is dropped without changing the held bytes. It sets `overflow`, which stays at 1 until a cycle with `ovf_clr` high.
- R5: `occ_code` equals the held count minus one, and reads 0 when the queue is empty.
- R6: With threshold value T, `level_irq` becomes 1 at the clock edge after the held count first reaches T+1. It stays 0 while the count is T or less.
- R7: `level_irq` stays 1, even while the queue drains to empty, until a cycle with `level_clr` high. After that edge it reads 0. One edge later it is 1 again if the count still exceeds T.
- R8: A pop requested while the queue is empty changes nothing.
- R9: A push and a pop in the same cycle, with the queue neither empty nor full, leave the count unchanged. Both bytes move.
- R10: A cycle with `thr_we` high loads `thr_wdata` into the threshold, which `thr_q` shows from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte offered by the shifter |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Queue has room; a beat offered without it is dropped |
| out_valid | output | 1 | A byte is held |
| out_data | output | 8 | Oldest held byte |
| out_ready | input | 1 | Pop strobe from a data-register read |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 4 | New threshold, count minus one |
| thr_q | output | 4 | Current threshold |
| occ_code | output | 4 | Held count minus one (0 when empty) |
| empty | output | 1 | No bytes held |
| full | output | 1 | 16 bytes held |
| overflow | output | 1 | Sticky: a beat was dropped |
| ovf_clr | input | 1 | Clears `overflow` |
| level_irq | output | 1 | Sticky fill-level interrupt request |
| level_clr | input | 1 | Clears `level_irq` |

## Verification
On every cycle, the assertions check the count bound, the overflow latch on a dropped beat, the inertness of an empty pop and of a balanced push/pop, and the set, hold and clear rules of the level interrupt. Data ordering cannot be shown by the assertions; neither can the exact cycle in which the interrupt first rises for each threshold value or the occupancy encoding. The bench's sweep over all 16 thresholds and all 16 fill levels shows these, together with the full-queue drop and the re-latch after a clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DEPTH = 16;
  localparam int RXQ_DW    = 8;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          ovf_clr,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count_q,
  output logic          empty,
  output logic          full,
  output logic          ovf_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CW'(DEPTH));
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;
  assign wr_en   = do_push;
  assign waddr   = wp_q;
  assign raddr   = rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_req && full) ovf_q <= 1'b1;
      else if (ovf_clr)     ovf_q <= 1'b0;
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  a_r4_ovf_latch: assert property (@(posedge clk) disable iff (rst)
    push_req && full |=> ovf_q);
  a_r4_drop_keeps: assert property (@(posedge clk) disable iff (rst)
    push_req && full && !pop_req |=> $stable(count_q));
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop_req && empty && !push_req |=> count_q == '0);
  a_r9_balanced: assert property (@(posedge clk) disable iff (rst)
    push_req && pop_req && !empty && !full |=> $stable(count_q));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_we,
  input  logic [AW-1:0] thr_wdata,
  input  logic          irq_clr,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] thr_q,
  output logic          irq_q
);
  logic hit;

  assign hit = count > CW'(thr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= AW'(DEPTH - 1);
      irq_q <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      if (irq_clr)  irq_q <= 1'b0;
      else if (hit) irq_q <= 1'b1;
    end
  end

  a_r6_level_sets: assert property (@(posedge clk) disable iff (rst)
    hit && !irq_clr |=> irq_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    irq_q && !irq_clr |=> irq_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq_q);
  a_r10_thr_load: assert property (@(posedge clk) disable iff (rst)
    thr_we |=> thr_q == $past(thr_wdata));
endmodule

// File: rtl/rxq_watermark_fifo.sv
module rxq_watermark_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = RXQ_DEPTH,
  parameter int DW    = RXQ_DW,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          thr_we,
  input  logic [AW-1:0] thr_wdata,
  output logic [AW-1:0] thr_q,
  output logic [AW-1:0] occ_code,
  output logic          empty,
  output logic          full,
  output logic          overflow,
  input  logic          ovf_clr,
  output logic          level_irq,
  input  logic          level_clr
);
  logic          wr_en;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .push_req(in_valid), .pop_req(out_ready),
    .ovf_clr(ovf_clr), .wr_en(wr_en), .waddr(waddr), .raddr(raddr),
    .count_q(count), .empty(empty), .full(full), .ovf_q(overflow)
  );

  rxq_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(out_data)
  );

  rxq_level #(.DEPTH(DEPTH)) level_i (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .irq_clr(level_clr), .count(count), .thr_q(thr_q), .irq_q(level_irq)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign occ_code  = empty ? '0 : AW'(count - 1'b1);
endmodule

// File: tb/rxq_watermark_fifo_tb_top.sv
module rxq_watermark_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b0, thr_we = 1'b0;
  logic       ovf_clr = 1'b0, level_clr = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] thr_wdata = '0;
  logic       in_ready, out_valid, empty, full, overflow, level_irq;
  logic [7:0] out_data;
  logic [3:0] thr_q, occ_code;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rxq_watermark_fifo dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_q(thr_q), .occ_code(occ_code), .empty(empty), .full(full),
    .overflow(overflow), .ovf_clr(ovf_clr), .level_irq(level_irq),
    .level_clr(level_clr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; tick(); in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1; tick(); out_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 thr", thr_q, 15);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 irq", level_irq, 0);
    chk("R1 ovf", overflow, 0);
    chk("R5 occ empty", occ_code, 0);
    chk("R3 out_valid", out_valid, 0);

    // Sweep every threshold across every fill level
    for (int t = 0; t < 16; t++) begin
      do_reset();
      thr_we = 1'b1; thr_wdata = 4'(t); tick(); thr_we = 1'b0;
      chk("R10 thr load", thr_q, t);
      for (int i = 0; i < 16; i++) begin
        push(8'(t * 16 + i));
        chk("R6 latency", level_irq, (i > t) ? 1 : 0);
        tick();
        chk("R5 occ", occ_code, i);
        chk("R6 level", level_irq, (i + 1 > t) ? 1 : 0);
        chk("R3 full", full, (i == 15) ? 1 : 0);
        chk("R3 in_ready", in_ready, (i == 15) ? 0 : 1);
        chk("R3 empty", empty, 0);
      end
      for (int i = 0; i < 16; i++) begin
        chk("R2 order", out_data, (t * 16 + i) % 256);
        chk("R3 out_valid", out_valid, 1);
        pop();
        chk("R7 sticky", level_irq, 1);
      end
      chk("R3 empty end", empty, 1);
      chk("R5 occ end", occ_code, 0);
    end

    // R4 overflow: drop while full
    do_reset();
    for (int i = 0; i < 16; i++) push(8'(100 + i));
    push(8'hAA);
    chk("R4 ovf set", overflow, 1);
    chk("R4 occ held", occ_code, 15);
    tick();
    chk("R4 ovf sticky", overflow, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R4 contents", out_data, 100 + i);
      pop();
    end
    chk("R4 drained", empty, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    chk("R4 ovf clear", overflow, 0);

    // R8 pop on empty
    pop();
    chk("R8 still empty", empty, 1);
    chk("R8 occ", occ_code, 0);
    push(8'h5C);
    chk("R8 data", out_data, 8'h5C);
    chk("R8 one held", occ_code, 0);
    chk("R8 not empty", empty, 0);

    // R9 balanced push/pop
    push(8'h11);
    in_valid = 1'b1; in_data = 8'h22; out_ready = 1'b1; tick();
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R9 occ same", occ_code, 1);
    chk("R9 head", out_data, 8'h11);
    pop();
    chk("R9 tail", out_data, 8'h22);

    // R7 clear with condition still true, then with condition gone
    do_reset();
    thr_we = 1'b1; thr_wdata = 4'd0; tick(); thr_we = 1'b0;
    push(8'h01);
    tick();
    chk("R7 set", level_irq, 1);
    level_clr = 1'b1; tick(); level_clr = 1'b0;
    chk("R7 cleared", level_irq, 0);
    tick();
    chk("R7 relatch", level_irq, 1);
    pop();
    tick();
    chk("R7 drained sticky", level_irq, 1);
    level_clr = 1'b1; tick(); level_clr = 1'b0;
    tick();
    chk("R7 stays clear", level_irq, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule